// File: doc/BRIEF.md
# Palette Host Register Port

This block is the host-side register port of a colour-palette video DAC. A host processor reaches a 16-entry register map through active-low read and write strobes, a 4-bit register-select address and an 8-bit data bus. None of these signals is tied to the system clock. The strobes pass through two-flop synchronizers, and edges are detected on the synchronized copies. A write is committed when its strobe rises. A read is launched when its strobe falls: the addressed entry is captured into a holding register and driven onto the data bus while the read strobe stays low.

A static mode pin selects between 8-bit and 6-bit palette data. The stored entries are always 8 bits wide, and the mode changes only how they are presented. In 6-bit mode, the word sent to the DAC output multiplexer is the low six bits moved up to the top, with zeros in the two LSBs. A host readback in 6-bit mode returns the low six bits with the two MSBs cleared. A separate index input picks the entry that feeds the registered DAC word.

Top module: `pal_host_port`

## Requirements
- R1: After reset, data_oe_o is 0, data_o is 0, dac_word_o is 0, and all 16 entries read back as 0.
- R2: A rising edge on wr_ni stores data_i into the entry addressed by rs_i. rs_i and data_i must be held for at least 4 clock cycles after the rise. The write is visible to reads and to the DAC path from the 3rd rising clock edge after the rise.
- R3: A falling edge on wr_ni followed by a rising edge is needed for a write. A falling edge on rd_ni captures the entry addressed by rs_i. From the 3rd rising clock edge after the fall, data_o holds the captured value and data_oe_o is 1, and both stay so until rd_ni rises.
- R4: data_oe_o goes to 0 by the 3rd rising clock edge after rd_ni rises. It stays 0 while rd_ni is high, and data_o does not change while data_oe_o is high.
- R5: When mode8_i is 1 at read time, the readback is the full stored 8-bit value, with bit 7 as MSB.
- R6: When mode8_i is 0 at read time, the readback is {2'b00, entry[5:0]}.
- R7: dac_word_o equals the entry selected by dac_idx_i one clock cycle after the index is sampled, unchanged when mode8_i is 1.
- R8: When mode8_i is 0, dac_word_o is {entry[5:0], 2'b00}: entry bit 5 drives DAC bit 7, entry bit 0 drives DAC bit 2, and bits 1:0 are 0.
- R9: Storage stays 8 bits wide in both modes. A value written in 6-bit mode reads back in full in 8-bit mode.
- R10: If the synchronized read and write strobes are both low in any cycle of a write pulse, that write is discarded and the entry keeps its previous value.
- R11: All 16 addresses select distinct entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_ni | input | 1 | Active-low host read strobe, asynchronous |
| wr_ni | input | 1 | Active-low host write strobe, asynchronous |
| rs_i | input | 4 | Register-select address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data from the holding register |
| data_oe_o | output | 1 | Data bus output enable |
| mode8_i | input | 1 | 1 = 8-bit data, 0 = 6-bit compatibility mode |
| dac_idx_i | input | 4 | Entry index feeding the DAC word |
| dac_word_o | output | 8 | Formatted word to the DAC output multiplexer |

## Verification
The assertions check on every cycle that the output enable stays low while the read strobe has been high, that the read data holds steady while it is enabled, and that the 6-bit formatting clears the readback MSBs and the DAC LSBs. Only the bench scenarios can show that the right entry is stored and returned at the right address. They also show that a write overlapped by a read is dropped, and that a 6-bit-mode write keeps all eight bits for a later 8-bit read.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned AW  = 4;
  localparam int unsigned PAD = 2;  // bits dropped in the narrow mode

  typedef logic [DW-1:0] word_t;

  // narrow mode: low bits shifted to the top, zero fill below
  function automatic word_t fmt_dac(word_t v, logic mode8);
    return mode8 ? v : {v[DW-PAD-1:0], {PAD{1'b0}}};
  endfunction

  // narrow mode: upper bits cleared on host readback
  function automatic word_t fmt_rd(word_t v, logic mode8);
    return mode8 ? v : {{PAD{1'b0}}, v[DW-PAD-1:0]};
  endfunction
endpackage

// File: rtl/pal_strobe_sync.sv
module pal_strobe_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = async_i;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '1;  // strobes idle high
      else         q <= chain[s-1];
    end
    assign chain[s] = q;
  end

  logic [W-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= chain[STAGES];
  end

  assign sync_o = chain[STAGES];
  assign prev_o = prev_q;
endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
  import pal_pkg::*;
#(
  parameter int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output word_t         rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output word_t         rdata_b_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
  import pal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] rs_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          mode8_i,
  input  logic [AW-1:0] dac_idx_i,
  output logic [DW-1:0] dac_word_o
);
  localparam int unsigned RD = 0;
  localparam int unsigned WR = 1;

  logic [1:0] strb_s, strb_p;

  pal_strobe_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({wr_ni, rd_ni}),
    .sync_o (strb_s),
    .prev_o (strb_p)
  );

  logic rd_fall, wr_fall, wr_rise;
  assign rd_fall = !strb_s[RD] &&  strb_p[RD];
  assign wr_fall = !strb_s[WR] &&  strb_p[WR];
  assign wr_rise =  strb_s[WR] && !strb_p[WR];

  // overlap of both strobes during a write pulse cancels that write
  logic clash_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      clash_q <= 1'b0;
    else if (wr_fall) clash_q <= !strb_s[RD];
    else              clash_q <= clash_q | (!strb_s[WR] && !strb_s[RD]);
  end

  word_t rd_word, dac_raw;

  pal_regfile u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_rise && !clash_q),
    .waddr_i  (rs_i),
    .wdata_i  (data_i),
    .raddr_a_i(rs_i),
    .rdata_a_o(rd_word),
    .raddr_b_i(dac_idx_i),
    .rdata_b_o(dac_raw)
  );

  word_t hold_q, dac_q;
  logic  oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else if (rd_fall) begin
      hold_q <= fmt_rd(rd_word, mode8_i);
      oe_q   <= 1'b1;
    end else if (strb_s[RD]) begin
      oe_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_q <= '0;
    else         dac_q <= fmt_dac(dac_raw, mode8_i);
  end

  assign data_o     = hold_q;
  assign data_oe_o  = oe_q;
  assign dac_word_o = dac_q;
endmodule

// File: rtl/pal_host_port_chk.sv
module pal_host_port_chk
  import pal_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_ni,
  input logic          mode8_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic [DW-1:0] dac_word_o
);
  assert_oe_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && $past(rd_ni) && $past(rd_ni, 2) && $past(rd_ni, 3)) |-> !data_oe_o);

  assert_rd_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

  assert_rd_msb_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && !$past(mode8_i)) |-> (data_o[DW-1 -: PAD] == '0));

  assert_dac_lsb_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mode8_i) |-> (dac_word_o[PAD-1:0] == '0));
endmodule

bind pal_host_port pal_host_port_chk u_chk (.*);

// File: tb/pal_host_port_test.sv
module pal_host_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_ni = 1'b1, wr_ni = 1'b1, mode8_i = 1'b1;
  logic [3:0] rs_i = '0, dac_idx_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o, dac_word_o;
  logic       data_oe_o;

  int checks = 0, errors = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pal_host_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .rs_i(rs_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .mode8_i(mode8_i), .dac_idx_i(dac_idx_i), .dac_word_o(dac_word_o)
  );

  function automatic logic [7:0] exp_rd(logic [7:0] v, logic m8);
    return m8 ? v : {2'b00, v[5:0]};
  endfunction

  function automatic logic [7:0] exp_dac(logic [7:0] v, logic m8);
    return m8 ? v : {v[5:0], 2'b00};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    rs_i = a; data_i = d; wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    wr_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    model[a] = d;
  endtask

  task automatic host_read(string req, logic [3:0] a);
    @(negedge clk_i);
    rs_i = a; rd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check({req, " oe"}, {7'd0, data_oe_o}, 8'd1);
    check({req, " data"}, data_o, exp_rd(model[a], mode8_i));
    rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R4 oe off", {7'd0, data_oe_o}, 8'd0);
  endtask

  task automatic dac_probe(string req, logic [3:0] idx);
    @(negedge clk_i);
    dac_idx_i = idx;
    repeat (2) @(negedge clk_i);
    check(req, dac_word_o, exp_dac(model[idx], mode8_i));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    check("R1 oe", {7'd0, data_oe_o}, 8'd0);
    check("R1 data", data_o, 8'd0);
    check("R1 dac", dac_word_o, 8'd0);
    host_read("R1 entry", 4'd9);

    // R11 distinct entries, R2 write, R5 full readback
    for (int a = 0; a < 16; a++) host_write(4'(a), 8'(8'hC3 ^ (a * 17)));
    for (int a = 0; a < 16; a++) host_read("R11 R5", 4'(a));
    host_write(4'd5, 8'hFF);
    host_read("R2 R3", 4'd5);

    // R7 DAC unchanged in 8-bit mode
    dac_probe("R7", 4'd5);
    dac_probe("R7", 4'd12);

    // R6 R8 narrow mode, R9 storage kept at 8 bits
    mode8_i = 1'b0;
    host_write(4'd3, 8'hE5);
    host_read("R6", 4'd3);
    dac_probe("R8", 4'd3);
    dac_probe("R8", 4'd5);
    mode8_i = 1'b1;
    host_read("R9", 4'd3);

    // R10 overlapping strobes drop the write
    @(negedge clk_i);
    rs_i = 4'd7; data_i = 8'h5A; wr_ni = 1'b0; rd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    wr_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    rd_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    host_read("R10", 4'd7);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r;
      logic [3:0]  a;
      logic [7:0]  d;
      r = $urandom();
      a = r[3:0];
      d = r[15:8];
      mode8_i = r[16];
      case (r[18:17])
        2'd0, 2'd1: host_write(a, d);
        2'd2:       host_read(mode8_i ? "R5 rnd" : "R6 rnd", a);
        default:    dac_probe(mode8_i ? "R7 rnd" : "R8 rnd", a);
      endcase
    end

    finish_run();
  end
endmodule